// File: doc/BRIEF.md
# Multi-Cycle Iterative Shifter

This block produces 32-bit shift results for an integer core that cannot afford a single-cycle barrel network. A shift request (operand, 5-bit amount, operation) is captured on a start strobe. The operand is then moved through a small per-cycle stage. Each cycle it advances by four positions while four or more remain, and by one position for the remainder. When the count is exhausted, the block raises a one-cycle done pulse with the result.

The sequencer has three named states. ST_IDLE waits for start. ST_SHIFT applies one step per cycle. ST_FINISH presents the result with done high. Its transitions are:
- ST_IDLE to ST_FINISH on start with a zero amount.
- ST_IDLE to ST_SHIFT on start with a non-zero amount.
- ST_SHIFT to ST_SHIFT while the step just taken leaves a count.
- ST_SHIFT to ST_FINISH on the step that empties the count.
- ST_FINISH to ST_IDLE unconditionally.

The result register holds its value after done until the next accepted start. The surrounding core reads it after the done pulse.

Top module: `iter_shifter`

## Requirements
- R1: After reset, busy and done are 0 and result is all zeros.
- R2: A start seen while busy is 0 is accepted at that clock edge. Busy is 1 from the next cycle through the done cycle, inclusive, and 0 in the cycle after done.
- R3: Operation code 2'b00 (and 2'b11) gives a logical left shift; vacated low bits are 0.
- R4: Operation code 2'b01 gives a logical right shift; vacated high bits are 0.
- R5: Operation code 2'b10 gives an arithmetic right shift; vacated high bits copy bit 31 of the captured operand.
- R6: For amount N, done rises floor(N/4) + (N mod 4) cycles after the first cycle following the accepting edge. An amount of 31 therefore takes 10 step cycles.
- R7: An amount of 0 gives done in the first cycle after the accepting edge, with result equal to the operand.
- R8: Done is high for exactly one cycle with the final result valid in that cycle. The result then holds unchanged while idle.
- R9: Start is ignored while busy is 1, including in the done cycle. Neither the result nor the timing of the running shift changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled when idle |
| op | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 as 00 |
| amount | input | 5 | Shift distance 0..31 |
| operand | input | 32 | Value to shift |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Shifted value, valid with done and held afterwards |

## Verification
Completion and a new request can coincide: a caller may raise start in the very cycle done is high, while busy is still asserted. The bench drives exactly that case. It places start with a different operand in the done cycle and expects busy low one cycle later, no second done, and the first result still on the output. A start raised in the middle of a multi-step shift is judged the same way, by unchanged latency and result.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic [1:0] {
        OP_SLL = 2'b00,
        OP_SRL = 2'b01,
        OP_SRA = 2'b10,
        OP_RSV = 2'b11
    } sh_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SHIFT  = 2'b01,
        ST_FINISH = 2'b10
    } sh_state_e;

endpackage

// File: rtl/shift_stage.sv
module shift_stage
    import shift_pkg::*;
#(
    parameter int W    = 32,
    parameter int STEP = 1
) (
    input  logic [W-1:0] din,
    input  sh_op_e       op,
    input  logic         fill,
    output logic [W-1:0] dout
);
    always_comb begin
        unique case (op)
            OP_SRL, OP_SRA: dout = {{STEP{fill}}, din[W-1:STEP]};
            default:        dout = {din[W-1-STEP:0], {STEP{1'b0}}};
        endcase
    end
endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl
    import shift_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic amt_zero,
    input  logic last_step,
    output logic load,
    output logic step_en,
    output logic busy,
    output logic done
);
    sh_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = amt_zero ? ST_FINISH : ST_SHIFT;
            ST_SHIFT:  if (last_step) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load    = 1'b0;
        step_en = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:   load = start;
            ST_SHIFT:  begin busy = 1'b1; step_en = 1'b1; end
            ST_FINISH: begin busy = 1'b1; done = 1'b1; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/iter_shifter.sv
module iter_shifter
    import shift_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int BIG_STEP = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               op,
    input  logic [$clog2(WIDTH)-1:0] amount,
    input  logic [WIDTH-1:0]         operand,
    output logic                     busy,
    output logic                     done,
    output logic [WIDTH-1:0]         result
);
    localparam int AW = $clog2(WIDTH);
    localparam logic [AW-1:0] BIG_W = AW'(BIG_STEP);
    localparam logic [AW-1:0] ONE_W = AW'(1);

    logic [WIDTH-1:0] data_q, small_nx, big_nx;
    logic [AW-1:0]    rem_q, rem_nx;
    sh_op_e           op_q;
    logic             sign_q, fill, use_big, last_step, load, step_en;

    assign fill      = (op_q == OP_SRA) ? sign_q : 1'b0;
    assign use_big   = (rem_q >= BIG_W);
    assign rem_nx    = rem_q - (use_big ? BIG_W : ONE_W);
    assign last_step = (rem_nx == '0);

    shift_stage #(.W(WIDTH), .STEP(1)) u_small (
        .din(data_q), .op(op_q), .fill(fill), .dout(small_nx)
    );
    shift_stage #(.W(WIDTH), .STEP(BIG_STEP)) u_big (
        .din(data_q), .op(op_q), .fill(fill), .dout(big_nx)
    );

    shift_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .amt_zero(amount == '0), .last_step(last_step),
        .load(load), .step_en(step_en), .busy(busy), .done(done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            rem_q  <= '0;
            op_q   <= OP_SLL;
            sign_q <= 1'b0;
        end else if (load) begin
            data_q <= operand;
            rem_q  <= amount;
            op_q   <= sh_op_e'(op);
            sign_q <= operand[WIDTH-1];
        end else if (step_en) begin
            data_q <= use_big ? big_nx : small_nx;
            rem_q  <= rem_nx;
        end
    end

    assign result = data_q;
endmodule

// File: rtl/shift_checks.sv
module shift_checks #(
    parameter int WIDTH = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic [$clog2(WIDTH)-1:0] amount,
    input logic [WIDTH-1:0]         operand,
    input logic                     busy,
    input logic                     done,
    input logic [WIDTH-1:0]         result
);
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    a_r9_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r2_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r7_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && amount == '0) |=> (done && result == $past(operand)));

    a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));
endmodule

bind iter_shifter shift_checks #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .amount(amount),
    .operand(operand), .busy(busy), .done(done), .result(result)
);

// File: tb/sim_iter_shifter.sv
`timescale 1ns/1ps
module sim_iter_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [4:0]  amount = '0;
    logic [31:0] operand = '0;
    logic        busy, done;
    logic [31:0] result;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    iter_shifter u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .amount(amount),
        .operand(operand), .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [1:0] o, input logic [31:0] d, input logic [4:0] a);
        case (o)
            2'b01:   return d >> a;
            2'b10:   return 32'($signed(d) >>> a);
            default: return d << a;
        endcase
    endfunction

    function automatic int steps(input logic [4:0] a);
        return int'(a) / 4 + int'(a) % 4;
    endfunction

    // issue a request, wait for done; returns at the negedge where done is seen
    task automatic run(input logic [1:0] o, input logic [31:0] d, input logic [4:0] a,
                       input string tag, output int lat);
        @(negedge clk); start = 1'b1; op = o; operand = d; amount = a;
        @(negedge clk); start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            chk(busy, "R2 busy while shifting", 32'(busy), 32'd1);
            @(negedge clk); lat++;
        end
        chk(busy, "R2 busy in done cycle", 32'(busy), 32'd1);
        chk(lat == steps(a), {tag, " R6 latency"}, 32'(lat), 32'(steps(a)));
        chk(result == model(o, d, a), {tag, " result"}, result, model(o, d, a));
    endtask

    task automatic t_reset();
        chk(!busy, "R1 busy", 32'(busy), 32'd0);
        chk(!done, "R1 done", 32'(done), 32'd0);
        chk(result == 32'd0, "R1 result", result, 32'd0);
    endtask

    task automatic t_after_done(input logic [31:0] exp);
        @(negedge clk);
        chk(!done, "R8 done single pulse", 32'(done), 32'd0);
        chk(!busy, "R2 idle after done", 32'(busy), 32'd0);
        repeat (3) @(negedge clk);
        chk(result == exp, "R8 result holds", result, exp);
    endtask

    task automatic t_sll();
        int lat;
        run(2'b00, 32'hDEAD_BEEF, 5'd7, "R3 sll", lat);
        t_after_done(model(2'b00, 32'hDEAD_BEEF, 5'd7));
        run(2'b11, 32'h8000_0001, 5'd4, "R3 code11", lat);
        t_after_done(model(2'b00, 32'h8000_0001, 5'd4));
    endtask

    task automatic t_srl();
        int lat;
        run(2'b01, 32'hF000_00F0, 5'd9, "R4 srl", lat);
        t_after_done(model(2'b01, 32'hF000_00F0, 5'd9));
        run(2'b01, 32'hFFFF_FFFF, 5'd3, "R4 srl small", lat);
        t_after_done(model(2'b01, 32'hFFFF_FFFF, 5'd3));
    endtask

    task automatic t_sra();
        int lat;
        run(2'b10, 32'h8123_4567, 5'd13, "R5 sra neg", lat);
        t_after_done(model(2'b10, 32'h8123_4567, 5'd13));
        run(2'b10, 32'h7123_4567, 5'd6, "R5 sra pos", lat);
        t_after_done(model(2'b10, 32'h7123_4567, 5'd6));
    endtask

    task automatic t_zero();
        int lat;
        run(2'b10, 32'hA5A5_0F0F, 5'd0, "R7 zero", lat);
        chk(result == 32'hA5A5_0F0F, "R7 unchanged", result, 32'hA5A5_0F0F);
        t_after_done(32'hA5A5_0F0F);
    endtask

    task automatic t_max();
        int lat;
        run(2'b10, 32'h8000_0000, 5'd31, "R6 max sra", lat);
        chk(lat == 10, "R6 ten steps", 32'(lat), 32'd10);
        t_after_done(32'hFFFF_FFFF);
        run(2'b00, 32'h0000_0001, 5'd31, "R6 max sll", lat);
        t_after_done(32'h8000_0000);
    endtask

    task automatic t_start_mid();
        int lat;
        @(negedge clk); start = 1'b1; op = 2'b01; operand = 32'hC0DE_1234; amount = 5'd22;
        @(negedge clk); start = 1'b0; lat = 0;
        while (!done && lat < 40) begin
            if (lat == 2 || lat == 3) begin
                start = 1'b1; op = 2'b00; operand = 32'h1111_1111; amount = 5'd1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk); lat++;
        end
        start = 1'b0;
        chk(lat == steps(5'd22), "R9 latency unchanged", 32'(lat), 32'(steps(5'd22)));
        chk(result == model(2'b01, 32'hC0DE_1234, 5'd22), "R9 result unchanged",
            result, model(2'b01, 32'hC0DE_1234, 5'd22));
        t_after_done(model(2'b01, 32'hC0DE_1234, 5'd22));
    endtask

    task automatic t_start_on_done();
        int lat;
        logic [31:0] exp;
        exp = model(2'b10, 32'h9000_0000, 5'd5);
        run(2'b10, 32'h9000_0000, 5'd5, "R9 overlap", lat);
        start = 1'b1; op = 2'b00; operand = 32'h0000_00FF; amount = 5'd0;
        @(negedge clk); start = 1'b0;
        chk(!busy, "R9 start in done cycle ignored (busy)", 32'(busy), 32'd0);
        chk(!done, "R9 no second done", 32'(done), 32'd0);
        chk(result == exp, "R9 result kept", result, exp);
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_sll();
        t_srl();
        t_sra();
        t_zero();
        t_max();
        t_start_mid();
        t_start_on_done();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule